// File: doc/BRIEF.md
# Buffer-Ring Stream Writer with Flush Handoff

This block takes a byte stream produced on the device side and writes it into a ring of equally sized host buffers, one buffer at a time. Each buffer is written from its first word onwards. When a buffer is complete, the block hands it to the host with its index and the number of valid bytes. The block then moves on to the next buffer in the ring. The host returns each buffer with a release once it has consumed the contents. A buffer the host still holds is never written.

A buffer can also be closed early. This happens when the stream delivers a short final word, or when the host issues a flush pulse because it wants data that is sitting in a partly filled buffer. In a flush, the block abandons the current buffer at its present fill, hands it over with its valid count, and acknowledges. Writing then resumes at the start of the next buffer. Under sustained traffic every buffer is handed over full. Partial buffers appear only when traffic is thin or a flush arrives.

The controller is a three-state machine:
- FILL accepts beats.
- DRAIN is the single cycle in which the closing write is on the write port.
- HAND presents the handoff and claims the buffer.

The transitions are:
- FILL→DRAIN on a beat that fills or closes the buffer.
- FILL→HAND on a pending flush with a non-empty buffer.
- DRAIN→HAND always.
- HAND→FILL always, advancing the ring index.

Top module: `dmab_ring_ctrl`

## Requirements
- R1: After reset `s_ready` is high, `wr_valid`, `hand_valid` and `flush_ack` are low, and the first buffer filled is index 0.
- R2: Every beat accepted (`s_valid` and `s_ready` high at a clock edge) produces exactly one write in the following cycle. The write carries the beat's data at address `BASE_ADDR + index*BUF_BYTES + word*DATA_BYTES`, where word counts from 0 within the buffer.
- R3: `s_bytes` (1 to DATA_BYTES) gives the number of valid low-order bytes of a beat. `wr_strb` bit k is set exactly when k < `s_bytes`. A beat with fewer than DATA_BYTES bytes closes the buffer, and the handoff count is the sum of the bytes written into it.
- R4: A buffer whose last word is written with all bytes valid is handed over with count BUF_BYTES. `hand_valid` is a one-cycle pulse in the cycle after the closing write.
- R5: Handoffs name buffer indices in strict ring order 0, 1, ..., NUM_BUFS-1, 0, ...
- R6: A handed-over buffer receives no write until `rel_valid` with its index has been given. While the next buffer in ring order is held, `s_ready` stays low, even if a different buffer is released.
- R7: A one-cycle `flush_req` while the current buffer holds bytes closes that buffer. It is handed over with its partial count, and `flush_ack` is asserted in the same cycle as that handoff, after the buffer's last write. The next accepted beat goes to word 0 of the next buffer.
- R8: A flush while the current buffer holds zero bytes is acknowledged with no handoff.
- R9: A flush sampled at the same edge as the beat that fills the buffer yields one full handoff and one acknowledge, given together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Stream beat offered |
| s_ready | output | 1 | Stream beat can be taken |
| s_data | input | 8*DATA_BYTES | Stream beat data, byte 0 in the low bits |
| s_bytes | input | clog2(DATA_BYTES+1) | Valid low bytes in the beat, 1..DATA_BYTES |
| wr_valid | output | 1 | Write request present |
| wr_addr | output | ADDR_W | Byte address of the write |
| wr_data | output | 8*DATA_BYTES | Write data |
| wr_strb | output | DATA_BYTES | Byte enables of the write |
| hand_valid | output | 1 | Buffer handed to host (one-cycle pulse) |
| hand_idx | output | clog2(NUM_BUFS) | Index of handed buffer |
| hand_bytes | output | clog2(BUF_BYTES+1) | Valid bytes in handed buffer |
| rel_valid | input | 1 | Host returns a buffer |
| rel_idx | input | clog2(NUM_BUFS) | Index of returned buffer |
| flush_req | input | 1 | One-cycle flush request pulse |
| flush_ack | output | 1 | Flush complete, buffer safe to read |

## Verification
The bench builds the block with three buffers of 32 bytes and four-byte words. The odd buffer count makes the index wrap at a value that is not a power of two, and exercises the wrap many times within a short run. Eight words per buffer let directed sequences reach the full-buffer edge quickly. That edge is used for the flush-on-final-beat collision. The small ring also lets the bench hold every buffer, so the stall path and the out-of-order release can be reached.

// File: rtl/dmab_pkg.sv
package dmab_pkg;

    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_HAND  = 2'd2
    } dmab_state_e;

endpackage

// File: rtl/dmab_hold_map.sv
module dmab_hold_map #(
    parameter int NUM_BUFS = 4,
    parameter int IW       = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                claim,
    input  logic [IW-1:0]       claim_idx,
    input  logic                rel_valid,
    input  logic [IW-1:0]       rel_idx,
    output logic [NUM_BUFS-1:0] held
);

    for (genvar g = 0; g < NUM_BUFS; g++) begin : g_slot
        logic hit_claim;
        logic hit_rel;
        assign hit_claim = claim && (claim_idx == IW'(g));
        assign hit_rel   = rel_valid && (rel_idx == IW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                held[g] <= 1'b0;
            end else if (hit_claim) begin
                held[g] <= 1'b1;
            end else if (hit_rel) begin
                held[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dmab_wr_port.sv
module dmab_wr_port #(
    parameter int              ADDR_W     = 32,
    parameter int              DATA_BYTES = 4,
    parameter int              BUF_BYTES  = 64,
    parameter int              IW         = 2,
    parameter int              OW         = 4,
    parameter int              BW         = 3,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    localparam int             DATA_W     = 8 * DATA_BYTES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  take,
    input  logic [IW-1:0]         idx,
    input  logic [OW-1:0]         off,
    input  logic [DATA_W-1:0]     data,
    input  logic [BW-1:0]         nbytes,
    output logic                  wr_valid,
    output logic [ADDR_W-1:0]     wr_addr,
    output logic [DATA_W-1:0]     wr_data,
    output logic [DATA_BYTES-1:0] wr_strb
);

    logic [ADDR_W-1:0]     addr_n;
    logic [DATA_BYTES-1:0] strb_n;

    assign addr_n = BASE_ADDR
                  + ADDR_W'(idx) * ADDR_W'(BUF_BYTES)
                  + ADDR_W'(off) * ADDR_W'(DATA_BYTES);

    for (genvar b = 0; b < DATA_BYTES; b++) begin : g_strb
        assign strb_n[b] = (nbytes > BW'(b));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            wr_strb  <= '0;
        end else begin
            wr_valid <= take;
            if (take) begin
                wr_addr <= addr_n;
                wr_data <= data;
                wr_strb <= strb_n;
            end
        end
    end

endmodule

// File: rtl/dmab_ring_ctrl.sv
module dmab_ring_ctrl
    import dmab_pkg::*;
#(
    parameter int                NUM_BUFS   = 4,
    parameter int                BUF_BYTES  = 64,
    parameter int                DATA_BYTES = 4,
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR  = 'h1000_0000,
    localparam int               DATA_W     = 8 * DATA_BYTES,
    localparam int               WORDS      = BUF_BYTES / DATA_BYTES,
    localparam int               IW         = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1,
    localparam int               OW         = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int               CW         = $clog2(BUF_BYTES + 1),
    localparam int               BW         = $clog2(DATA_BYTES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  s_valid,
    output logic                  s_ready,
    input  logic [DATA_W-1:0]     s_data,
    input  logic [BW-1:0]         s_bytes,
    output logic                  wr_valid,
    output logic [ADDR_W-1:0]     wr_addr,
    output logic [DATA_W-1:0]     wr_data,
    output logic [DATA_BYTES-1:0] wr_strb,
    output logic                  hand_valid,
    output logic [IW-1:0]         hand_idx,
    output logic [CW-1:0]         hand_bytes,
    input  logic                  rel_valid,
    input  logic [IW-1:0]         rel_idx,
    input  logic                  flush_req,
    output logic                  flush_ack
);

    dmab_state_e       st_q, st_d;
    logic [IW-1:0]     idx_q, idx_d, idx_next;
    logic [OW-1:0]     off_q, off_d;
    logic [CW-1:0]     cnt_q, cnt_d, cnt_sum;
    logic              pend_q, pend_d;
    logic [NUM_BUFS-1:0] held_q;
    logic              take;
    logic              closing;
    logic              claim;

    assign idx_next = (idx_q == IW'(NUM_BUFS - 1)) ? '0 : idx_q + 1'b1;
    assign cnt_sum  = cnt_q + CW'(s_bytes);
    assign take     = s_valid && s_ready;
    assign closing  = take && ((s_bytes != BW'(DATA_BYTES)) || (off_q == OW'(WORDS - 1)));
    assign claim    = (st_q == ST_HAND);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_FILL;
            idx_q  <= '0;
            off_q  <= '0;
            cnt_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            idx_q  <= idx_d;
            off_q  <= off_d;
            cnt_q  <= cnt_d;
            pend_q <= pend_d;
        end
    end

    // next-state logic
    always_comb begin
        st_d   = st_q;
        idx_d  = idx_q;
        off_d  = off_q;
        cnt_d  = cnt_q;
        pend_d = flush_req || (pend_q && !flush_ack);
        unique case (st_q)
            ST_FILL: begin
                if (take) begin
                    cnt_d = cnt_sum;
                    if (closing) begin
                        st_d = ST_DRAIN;
                    end else begin
                        off_d = off_q + 1'b1;
                    end
                end else if (pend_q && (cnt_q != '0)) begin
                    st_d = ST_HAND;
                end
            end
            ST_DRAIN: begin
                st_d = ST_HAND;
            end
            ST_HAND: begin
                st_d  = ST_FILL;
                idx_d = idx_next;
                off_d = '0;
                cnt_d = '0;
            end
            default: begin
                st_d = ST_FILL;
            end
        endcase
    end

    // outputs
    always_comb begin
        s_ready    = (st_q == ST_FILL) && !pend_q && !held_q[idx_q];
        hand_valid = (st_q == ST_HAND);
        hand_idx   = idx_q;
        hand_bytes = cnt_q;
        flush_ack  = pend_q && ((st_q == ST_HAND) ||
                                ((st_q == ST_FILL) && (cnt_q == '0)));
    end

    dmab_hold_map #(
        .NUM_BUFS (NUM_BUFS),
        .IW       (IW)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .claim     (claim),
        .claim_idx (idx_q),
        .rel_valid (rel_valid),
        .rel_idx   (rel_idx),
        .held      (held_q)
    );

    dmab_wr_port #(
        .ADDR_W     (ADDR_W),
        .DATA_BYTES (DATA_BYTES),
        .BUF_BYTES  (BUF_BYTES),
        .IW         (IW),
        .OW         (OW),
        .BW         (BW),
        .BASE_ADDR  (BASE_ADDR)
    ) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .idx      (idx_q),
        .off      (off_q),
        .data     (s_data),
        .nbytes   (s_bytes),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_strb  (wr_strb)
    );

endmodule

// File: rtl/dmab_ring_sva.sv
module dmab_ring_sva #(
    parameter int NUM_BUFS   = 4,
    parameter int BUF_BYTES  = 64,
    parameter int DATA_BYTES = 4,
    parameter int IW         = 2,
    parameter int CW         = 7
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  s_valid,
    input logic                  s_ready,
    input logic                  wr_valid,
    input logic [DATA_BYTES-1:0] wr_strb,
    input logic                  hand_valid,
    input logic [IW-1:0]         hand_idx,
    input logic [CW-1:0]         hand_bytes,
    input logic [NUM_BUFS-1:0]   held
);

    logic [IW-1:0] ring_pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_pos <= '0;
        end else if (hand_valid) begin
            ring_pos <= (ring_pos == IW'(NUM_BUFS - 1)) ? '0 : ring_pos + 1'b1;
        end
    end

    a_r2_write_follows_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> wr_valid);

    a_r2_no_spurious_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_valid && s_ready) |=> !wr_valid);

    a_r3_strobe_low_run: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ((wr_strb != '0) && (((wr_strb + 1'b1) & wr_strb) == '0)));

    a_r4_hand_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        hand_valid |=> !hand_valid);

    a_r4_hand_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        hand_valid |-> ((hand_bytes != '0) && (hand_bytes <= CW'(BUF_BYTES))));

    a_r5_ring_order: assert property (@(posedge clk) disable iff (!rst_n)
        hand_valid |-> (hand_idx == ring_pos));

    a_r6_not_handed_twice: assert property (@(posedge clk) disable iff (!rst_n)
        hand_valid |-> !held[hand_idx]);

endmodule

bind dmab_ring_ctrl dmab_ring_sva #(
    .NUM_BUFS   (NUM_BUFS),
    .BUF_BYTES  (BUF_BYTES),
    .DATA_BYTES (DATA_BYTES),
    .IW         (IW),
    .CW         (CW)
) u_sva (
    .clk        (clk),
    .rst_n      (rst_n),
    .s_valid    (s_valid),
    .s_ready    (s_ready),
    .wr_valid   (wr_valid),
    .wr_strb    (wr_strb),
    .hand_valid (hand_valid),
    .hand_idx   (hand_idx),
    .hand_bytes (hand_bytes),
    .held       (held_q)
);

// File: tb/dmab_ring_ctrl_bench.sv
`timescale 1ns/1ps
module dmab_ring_ctrl_bench;

    localparam int          NB   = 3;
    localparam int          BB   = 32;
    localparam int          DB   = 4;
    localparam int          WDS  = BB / DB;
    localparam logic [31:0] BASE = 32'h0004_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0;
    logic        s_ready;
    logic [31:0] s_data = '0;
    logic [2:0]  s_bytes = 3'd4;
    logic        wr_valid;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  wr_strb;
    logic        hand_valid;
    logic [1:0]  hand_idx;
    logic [5:0]  hand_bytes;
    logic        rel_valid = 1'b0;
    logic [1:0]  rel_idx = '0;
    logic        flush_req = 1'b0;
    logic        flush_ack;

    always #4 clk = ~clk;

    dmab_ring_ctrl #(
        .NUM_BUFS   (NB),
        .BUF_BYTES  (BB),
        .DATA_BYTES (DB),
        .ADDR_W     (32),
        .BASE_ADDR  (BASE)
    ) u_dmab_ring_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .s_valid    (s_valid),
        .s_ready    (s_ready),
        .s_data     (s_data),
        .s_bytes    (s_bytes),
        .wr_valid   (wr_valid),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .wr_strb    (wr_strb),
        .hand_valid (hand_valid),
        .hand_idx   (hand_idx),
        .hand_bytes (hand_bytes),
        .rel_valid  (rel_valid),
        .rel_idx    (rel_idx),
        .flush_req  (flush_req),
        .flush_ack  (flush_ack)
    );

    int n_chk = 0;
    int n_bad = 0;

    // reference model state
    int          m_idx = 0;
    int          m_off = 0;
    int          m_cnt = 0;
    bit          held[NB];
    int          rel_timer[NB];
    logic [31:0] dq[$];
    int          bq[$];
    int          ehi[$];
    int          ehb[$];
    int          n_wr = 0, n_hand = 0, n_ack = 0, n_req = 0;
    int          last_hand_bytes = 0;
    bit          flush_out = 0;

    // stimulus controls
    int          p_valid = 0, p_short = 0, p_flush_pm = 0;
    int          beats_left = -1;
    bit          auto_rel = 1;
    int          rel_min = 1, rel_span = 4;
    bit          do_flush = 0, flush_with_beat = 0;
    bit          have = 0;
    logic [31:0] cur_d = '0;
    int          cur_b = DB;

    function automatic logic [31:0] exp_addr(int idx, int off);
        return BASE + 32'(idx * BB) + 32'(off * DB);
    endfunction

    function automatic logic [3:0] exp_strb(int nb);
        return 4'((1 << nb) - 1);
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic monitor();
        logic [31:0] d;
        int          b;
        if (wr_valid) begin
            n_wr++;
            if (dq.size() == 0) begin
                chk(0, "R2", "write without accepted beat", 1, 0);
            end else begin
                d = dq.pop_front();
                b = bq.pop_front();
                chk(wr_addr == exp_addr(m_idx, m_off), "R2", "write address", wr_addr, exp_addr(m_idx, m_off));
                chk(wr_data == d, "R2", "write data", wr_data, d);
                chk(wr_strb == exp_strb(b), "R3", "byte strobe", wr_strb, exp_strb(b));
                chk(!held[m_idx], "R6", "write into held buffer", m_idx, -1);
                m_cnt += b;
                if (b < DB || m_off == WDS - 1) begin
                    ehi.push_back(m_idx);
                    ehb.push_back(m_cnt);
                    m_idx = (m_idx + 1) % NB;
                    m_off = 0;
                    m_cnt = 0;
                end else begin
                    m_off++;
                end
            end
        end
        if (hand_valid) begin
            n_hand++;
            last_hand_bytes = int'(hand_bytes);
            if (ehi.size() > 0) begin
                int ei, eb;
                ei = ehi.pop_front();
                eb = ehb.pop_front();
                chk(int'(hand_idx) == ei, "R5", "handoff index", hand_idx, ei);
                chk(int'(hand_bytes) == eb, "R4", "handoff byte count", hand_bytes, eb);
            end else begin
                chk(flush_ack == 1'b1, "R7", "flush handoff without ack", flush_ack, 1);
                chk(int'(hand_idx) == m_idx, "R5", "flush handoff index", hand_idx, m_idx);
                chk(m_cnt > 0 && int'(hand_bytes) == m_cnt, "R7", "flush partial count", hand_bytes, m_cnt);
                m_idx = (m_idx + 1) % NB;
                m_off = 0;
                m_cnt = 0;
            end
            held[hand_idx] = 1'b1;
            rel_timer[hand_idx] = auto_rel ? (rel_min + int'($urandom % rel_span)) : -1;
        end
        if (flush_ack) begin
            n_ack++;
            chk(flush_out, "R7", "acknowledge without request", 1, 0);
            flush_out = 0;
            if (!hand_valid) begin
                chk(m_cnt == 0 && ehi.size() == 0, "R8", "ack without handoff on non-empty buffer", m_cnt, 0);
            end
        end
    endtask

    task automatic drive();
        rel_valid = 1'b0;
        for (int i = 0; i < NB; i++) begin
            if (rel_timer[i] == 0 && !rel_valid) begin
                rel_valid = 1'b1;
                rel_idx = 2'(i);
                held[i] = 1'b0;
                rel_timer[i] = -1;
            end else if (rel_timer[i] > 0) begin
                rel_timer[i]--;
            end
        end
        if (!have && beats_left != 0 && int'($urandom % 100) < p_valid) begin
            have = 1;
            cur_d = $urandom;
            cur_b = (int'($urandom % 100) < p_short) ? 1 + int'($urandom % (DB - 1)) : DB;
        end
        s_valid = have;
        s_data = cur_d;
        s_bytes = 3'(cur_b);
        flush_req = 1'b0;
        if (have && s_ready) begin
            dq.push_back(cur_d);
            bq.push_back(cur_b);
            have = 0;
            if (beats_left > 0) beats_left--;
            if (flush_with_beat && !flush_out) begin
                flush_req = 1'b1;
                flush_out = 1;
                n_req++;
                flush_with_beat = 0;
            end
        end
        if (!flush_req && !flush_out && (do_flush || int'($urandom % 1000) < p_flush_pm)) begin
            flush_req = 1'b1;
            flush_out = 1;
            n_req++;
            do_flush = 0;
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        monitor();
        drive();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic flush_and_wait();
        do_flush = 1;
        cyc();
        for (int i = 0; i < 60 && (flush_out || do_flush); i++) cyc();
        chk(!flush_out, "R7", "flush acknowledged in time", flush_out, 0);
        run(3);
    endtask

    task automatic quiesce();
        p_valid = 0;
        run(30);
        if (m_cnt != 0) flush_and_wait();
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        int h0, a0, w0;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NB; i++) begin
            held[i] = 0;
            rel_timer[i] = -1;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(s_ready == 1'b1, "R1", "ready after reset", s_ready, 1);
        chk(wr_valid == 1'b0, "R1", "no write after reset", wr_valid, 0);
        chk(hand_valid == 1'b0, "R1", "no handoff after reset", hand_valid, 0);
        chk(flush_ack == 1'b0, "R1", "no ack after reset", flush_ack, 0);

        // R4: heavy load, every buffer handed full, fast release
        p_valid = 100; p_short = 0; p_flush_pm = 0;
        auto_rel = 1; rel_min = 1; rel_span = 3;
        h0 = n_hand;
        run(200);
        chk(n_hand - h0 >= 10, "R4", "full handoffs under load", n_hand - h0, 10);

        // R8: flush on an empty buffer
        quiesce();
        h0 = n_hand;
        a0 = n_ack;
        flush_and_wait();
        chk(n_hand == h0, "R8", "no handoff for empty flush", n_hand, h0);
        chk(n_ack == a0 + 1, "R8", "one ack for empty flush", n_ack, a0 + 1);

        // R7: partial flush after three words
        beats_left = 3; p_valid = 100;
        run(10);
        p_valid = 0;
        h0 = n_hand;
        flush_and_wait();
        chk(n_hand == h0 + 1, "R7", "partial flush handoff count", n_hand, h0 + 1);
        chk(last_hand_bytes == 3 * DB, "R7", "partial flush bytes", last_hand_bytes, 3 * DB);
        beats_left = 1; p_valid = 100;
        run(6);
        chk(m_off == 1 && m_cnt == DB, "R7", "writing resumed at word 0", m_off, 1);
        p_valid = 0;
        flush_and_wait();

        // R3: short beat closes the buffer
        beats_left = 2; p_valid = 100;
        run(8);
        p_valid = 0;
        h0 = n_hand;
        beats_left = 1; p_short = 100; p_valid = 100;
        run(8);
        p_short = 0; p_valid = 0;
        chk(n_hand == h0 + 1, "R3", "short beat closes buffer", n_hand, h0 + 1);
        chk(last_hand_bytes > 2 * DB && last_hand_bytes < 3 * DB, "R3", "short beat count", last_hand_bytes, 2 * DB + 1);

        // R9: flush on the filling beat
        quiesce();
        beats_left = WDS - 1; p_valid = 100;
        run(20);
        p_valid = 0;
        h0 = n_hand;
        a0 = n_ack;
        flush_with_beat = 1;
        beats_left = 1; p_valid = 100;
        run(12);
        p_valid = 0;
        chk(n_hand == h0 + 1, "R9", "single handoff", n_hand, h0 + 1);
        chk(n_ack == a0 + 1, "R9", "single ack", n_ack, a0 + 1);
        chk(last_hand_bytes == BB, "R9", "full count", last_hand_bytes, BB);

        // R6: all buffers held, stall and strict-order resume
        run(20);
        auto_rel = 0;
        beats_left = -1; p_valid = 100;
        run(80);
        chk(s_ready == 1'b0, "R6", "ready low with ring full", s_ready, 0);
        w0 = n_wr;
        run(10);
        chk(n_wr == w0, "R6", "no writes while stalled", n_wr, w0);
        rel_timer[(m_idx + 1) % NB] = 0;
        run(8);
        chk(n_wr == w0, "R6", "release of other buffer keeps stall", n_wr, w0);
        chk(s_ready == 1'b0, "R6", "ready still low", s_ready, 0);
        rel_timer[m_idx] = 0;
        run(5);
        chk(n_wr > w0, "R6", "writes resume after in-order release", n_wr, w0 + 1);
        auto_rel = 1; rel_min = 1; rel_span = 6;
        for (int i = 0; i < NB; i++) if (held[i] && rel_timer[i] < 0) rel_timer[i] = 2 + i;

        // random traffic
        p_valid = 60; p_short = 15; p_flush_pm = 30;
        rel_min = 1; rel_span = 30;
        run(3000);

        // drain
        p_flush_pm = 0;
        quiesce();
        run(40);
        chk(n_ack == n_req, "R7", "every flush acknowledged once", n_ack, n_req);
        chk(ehi.size() == 0, "R4", "no handoff left outstanding", ehi.size(), 0);
        chk(dq.size() == 0, "R2", "every beat written", dq.size(), 0);
        finish_run();
    end

endmodule